// File: doc/BRIEF.md
# Virtual Lane Timestamp Offset Generator

This block produces the per-virtual-lane timing offsets and the transmit extra-latency word for a multi-lane Ethernet path that carries precision timestamps. A start pulse captures the configuration: the virtual lane count, the physical lane grouping, the forward error correction mode, the unit interval, the PMA delay in unit intervals and the external PHY delay. From the cycle after the start pulse the block walks the virtual lanes in increasing order and presents one offset per cycle on a valid/index/value stream. A one-cycle done pulse follows the last lane.

An offset grows with the number of complete physical-lane groups that come before the lane. Each group adds one coded block length, counted in unit intervals. The unit interval arrives as 4 bits of nanoseconds and 28 bits of fraction. All results use a 16-bit fractional-nanosecond format, so the extra 12 fraction bits are dropped by truncation. The extra-latency word is always a positive adjustment. For single-lane rates a disable input suppresses the offset stream, and only the latency word and the done pulse are produced.

Top module: `vl_offset_gen`

## Requirements
- R1: The offset reported for virtual lane 0 is always zero.
- R2: The offset for lane v is floor(floor(v / P) * K * ui_val / 4096), where P is the physical lane count and K is the block multiplier. The fraction is truncated toward zero.
- R3: fec_sel selects K as follows: 2'b00 gives 1 (no FEC), 2'b01 gives 66, 2'b10 gives 68 and 2'b11 gives 68.
- R4: pl_sel selects P as follows: 2'b00 gives 1, 2'b01 gives 2, and 2'b10 and 2'b11 both give 4.
- R5: After an accepted start, ofs_valid is high for exactly N consecutive cycles, starting in the cycle after the start edge. ofs_index counts 0 to N-1 in those cycles.
- R6: done is a one-cycle pulse in the cycle after the last lane. It is never high together with ofs_valid.
- R7: lat_valid pulses in the cycle after an accepted start. lat_word[31] is 0, and lat_word[30:0] equals (floor(pma_delay_ui * ui_val / 4096) + ext_phy_delay) mod 2^31. lat_word holds until the next accepted start.
- R8: When disable_vl is high or vl_count is 0 at start, no offsets are emitted, and done and lat_valid both pulse in the cycle after the start edge.
- R9: A vl_count above MAX_VL (20) is treated as MAX_VL.
- R10: A start pulse that arrives while lanes are still being emitted is ignored. The stream and lat_word stay unchanged.
- R11: While reset is held, and in the first cycle after it is released, ofs_valid, lat_valid, done, ofs_index, ofs_value and lat_word are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation with the present configuration |
| disable_vl | input | 1 | Single-lane rate: no lane offsets |
| vl_count | input | IDX_W (5) | Number of virtual lanes |
| pl_sel | input | 2 | Physical lane count code |
| fec_sel | input | 2 | FEC mode code |
| ui_val | input | 32 | Unit interval, 4-bit ns and 28-bit fraction |
| pma_delay_ui | input | 16 | PMA delay in unit intervals |
| ext_phy_delay | input | 31 | External PHY delay, 16-bit fractional ns |
| ofs_valid | output | 1 | Lane offset present |
| ofs_index | output | IDX_W (5) | Virtual lane number of the offset |
| ofs_value | output | 32 | Lane offset, 16-bit fractional ns |
| lat_valid | output | 1 | Extra-latency word updated |
| lat_word | output | 32 | Extra-latency word, bit 31 is the sign |
| done | output | 1 | All lanes emitted |

## Verification
The latency result and the lane stream share the cycle right after start. lat_valid rises together with the lane-0 offset, or together with done when lanes are skipped through disable_vl or a zero count. The vector loop checks lat_word and the first offset in that same sampled cycle. A directed run with disable_vl set checks that done and lat_valid coincide while ofs_valid stays low. A second pairing is a new start arriving while lanes are in flight. That start is driven mid-stream with a changed configuration, and every later offset and the held lat_word are compared against the values of the original configuration.

// File: rtl/vlo_pkg.sv
package vlo_pkg;
  localparam int UI_W      = 32;
  localparam int UI_FRAC   = 28;
  localparam int OUT_FRAC  = 16;
  localparam int DROP_BITS = UI_FRAC - OUT_FRAC;
  localparam int KMAX_W    = 7;
  localparam int STEP_W    = UI_W + KMAX_W;

  typedef enum logic [1:0] {
    FEC_NONE = 2'b00,
    FEC_KR   = 2'b01,
    FEC_KP   = 2'b10,
    FEC_LL   = 2'b11
  } fec_mode_e;

  // Block multiplier chosen by the FEC mode
  function automatic logic [KMAX_W-1:0] block_mult(input logic [1:0] fec);
    case (fec_mode_e'(fec))
      FEC_KR:  return 7'd66;
      FEC_KP:  return 7'd68;
      FEC_LL:  return 7'd68;
      default: return 7'd1;
    endcase
  endfunction

  // Low index bits that must be zero at a group boundary
  function automatic logic [1:0] group_mask(input logic [1:0] pl_code);
    case (pl_code)
      2'b00:   return 2'b00;
      2'b01:   return 2'b01;
      default: return 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/vlo_step_calc.sv
module vlo_step_calc
  import vlo_pkg::*;
(
  input  logic [UI_W-1:0]   ui,
  input  logic [1:0]        fec,
  output logic [STEP_W-1:0] step
);
  logic [STEP_W-1:0] ui_ext;
  assign ui_ext = {{KMAX_W{1'b0}}, ui};

  // K * UI built from shifts: 66 = 64 + 2, 68 = 64 + 4
  always_comb begin
    case (fec_mode_e'(fec))
      FEC_KR:  step = (ui_ext << 6) + (ui_ext << 1);
      FEC_KP,
      FEC_LL:  step = (ui_ext << 6) + (ui_ext << 2);
      default: step = ui_ext;
    endcase
  end
endmodule

// File: rtl/vlo_latency_calc.sv
module vlo_latency_calc
  import vlo_pkg::*;
#(
  parameter int PMA_W = 16,
  parameter int EXT_W = 31
) (
  input  logic [UI_W-1:0]  ui,
  input  logic [PMA_W-1:0] pma_ui,
  input  logic [EXT_W-1:0] ext_delay,
  output logic [EXT_W:0]   word
);
  localparam int PROD_W = UI_W + PMA_W;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] prod_ns;
  logic [EXT_W-1:0]  sum;

  assign prod    = {{PMA_W{1'b0}}, ui} * {{UI_W{1'b0}}, pma_ui};
  assign prod_ns = prod >> DROP_BITS;
  assign sum     = prod_ns[EXT_W-1:0] + ext_delay;
  assign word    = {1'b0, sum};
endmodule

// File: rtl/vlo_lane_walker.sv
module vlo_lane_walker
  import vlo_pkg::*;
#(
  parameter int MAX_VL = 20,
  parameter int IDX_W  = 5,
  parameter int OFS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              skip,
  input  logic [IDX_W-1:0]  n_lanes,
  input  logic [1:0]        grp_mask,
  input  logic [STEP_W-1:0] step,
  output logic              accept,
  output logic              running,
  output logic [IDX_W-1:0]  idx,
  output logic [OFS_W-1:0]  offset,
  output logic              done,
  output logic              group_adv,
  output logic              at_last
);
  localparam int ACC_W = STEP_W + IDX_W;

  logic [ACC_W-1:0]  acc;
  logic [STEP_W-1:0] step_q;
  logic [1:0]        mask_q;
  logic [IDX_W-1:0]  last_q;
  logic [IDX_W-1:0]  idx_nxt;
  logic              skip_w;

  assign accept    = start && !running;
  assign skip_w    = skip || (n_lanes == '0);
  assign idx_nxt   = idx + 1'b1;
  assign at_last   = running && (idx == last_q);
  assign group_adv = running && !at_last && ((idx_nxt[1:0] & mask_q) == 2'b00);
  assign offset    = acc[DROP_BITS +: OFS_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      idx     <= '0;
      acc     <= '0;
      step_q  <= '0;
      mask_q  <= '0;
      last_q  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        idx     <= '0;
        acc     <= '0;
        step_q  <= step;
        mask_q  <= grp_mask;
        last_q  <= n_lanes - 1'b1;
        running <= !skip_w;
        done    <= skip_w;
      end else if (running) begin
        if (at_last) begin
          running <= 1'b0;
          done    <= 1'b1;
        end else begin
          idx <= idx_nxt;
          if (group_adv) acc <= acc + {{IDX_W{1'b0}}, step_q};
        end
      end
    end
  end
endmodule

// File: rtl/vl_offset_gen.sv
module vl_offset_gen
  import vlo_pkg::*;
#(
  parameter int MAX_VL = 20,
  parameter int IDX_W  = $clog2(MAX_VL + 1),
  parameter int PMA_W  = 16,
  parameter int EXT_W  = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             disable_vl,
  input  logic [IDX_W-1:0] vl_count,
  input  logic [1:0]       pl_sel,
  input  logic [1:0]       fec_sel,
  input  logic [UI_W-1:0]  ui_val,
  input  logic [PMA_W-1:0] pma_delay_ui,
  input  logic [EXT_W-1:0] ext_phy_delay,
  output logic             ofs_valid,
  output logic [IDX_W-1:0] ofs_index,
  output logic [31:0]      ofs_value,
  output logic             lat_valid,
  output logic [EXT_W:0]   lat_word,
  output logic             done
);
  localparam logic [IDX_W-1:0] MAX_CNT = IDX_W'(MAX_VL);

  logic [STEP_W-1:0] step_w;
  logic [EXT_W:0]    lat_calc;
  logic [IDX_W-1:0]  n_eff;
  logic              w_accept;
  logic              w_group_adv;
  logic              w_last;

  assign n_eff = (vl_count > MAX_CNT) ? MAX_CNT : vl_count;

  vlo_step_calc u_step (
    .ui  (ui_val),
    .fec (fec_sel),
    .step(step_w)
  );

  vlo_latency_calc #(.PMA_W(PMA_W), .EXT_W(EXT_W)) u_lat (
    .ui       (ui_val),
    .pma_ui   (pma_delay_ui),
    .ext_delay(ext_phy_delay),
    .word     (lat_calc)
  );

  vlo_lane_walker #(.MAX_VL(MAX_VL), .IDX_W(IDX_W), .OFS_W(32)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .skip     (disable_vl),
    .n_lanes  (n_eff),
    .grp_mask (group_mask(pl_sel)),
    .step     (step_w),
    .accept   (w_accept),
    .running  (ofs_valid),
    .idx      (ofs_index),
    .offset   (ofs_value),
    .done     (done),
    .group_adv(w_group_adv),
    .at_last  (w_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_valid <= 1'b0;
      lat_word  <= '0;
    end else begin
      lat_valid <= w_accept;
      if (w_accept) lat_word <= lat_calc;
    end
  end
endmodule

// File: rtl/vl_offset_gen_chk.sv
module vl_offset_gen_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             ofs_valid,
  input logic [IDX_W-1:0] ofs_index,
  input logic [31:0]      ofs_value,
  input logic             lat_valid,
  input logic [31:0]      lat_word,
  input logic             done,
  input logic             w_group_adv,
  input logic             w_last
);
  assert_lane0_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_valid && ofs_index == '0) |-> ofs_value == 32'd0);

  assert_offset_steps_on_group_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_valid && $past(ofs_valid) && ofs_value != $past(ofs_value)) |-> $past(w_group_adv));

  assert_index_consecutive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_valid && $past(ofs_valid)) |-> ofs_index == $past(ofs_index) + 1'b1);

  assert_stream_starts_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ofs_valid) |-> ofs_index == '0);

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    w_last |=> (done && !ofs_valid));

  assert_done_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && ofs_valid));

  assert_latency_positive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lat_word[31] == 1'b0);

  assert_latency_follows_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lat_valid |-> $past(start));

  assert_latency_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat_valid && $past(rst_n)) |-> $stable(lat_word));
endmodule

bind vl_offset_gen vl_offset_gen_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .ofs_valid  (ofs_valid),
  .ofs_index  (ofs_index),
  .ofs_value  (ofs_value),
  .lat_valid  (lat_valid),
  .lat_word   (lat_word),
  .done       (done),
  .w_group_adv(w_group_adv),
  .w_last     (w_last)
);

// File: tb/vl_offset_gen_bench.sv
module vl_offset_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        disable_vl = 1'b0;
  logic [4:0]  vl_count = '0;
  logic [1:0]  pl_sel = '0;
  logic [1:0]  fec_sel = '0;
  logic [31:0] ui_val = '0;
  logic [15:0] pma_delay_ui = '0;
  logic [30:0] ext_phy_delay = '0;
  logic        ofs_valid;
  logic [4:0]  ofs_index;
  logic [31:0] ofs_value;
  logic        lat_valid;
  logic [31:0] lat_word;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  vl_offset_gen u_vl_offset_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .disable_vl(disable_vl),
    .vl_count(vl_count), .pl_sel(pl_sel), .fec_sel(fec_sel), .ui_val(ui_val),
    .pma_delay_ui(pma_delay_ui), .ext_phy_delay(ext_phy_delay),
    .ofs_valid(ofs_valid), .ofs_index(ofs_index), .ofs_value(ofs_value),
    .lat_valid(lat_valid), .lat_word(lat_word), .done(done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 50000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // vector: {pl, fec, count, ui, pma, ext, dis}
  typedef struct packed {
    logic [1:0]  pl;
    logic [1:0]  fec;
    logic [4:0]  cnt;
    logic [31:0] ui;
    logic [15:0] pma;
    logic [30:0] ext;
    logic        dis;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'b01, 2'b10, 5'd8,  32'h01A2B3C4, 16'd100,   31'd500,        1'b0},
    '{2'b00, 2'b01, 5'd4,  32'h10000000, 16'd3,     31'd7,          1'b0},
    '{2'b10, 2'b11, 5'd20, 32'h09B4B4B5, 16'd1234,  31'd0,          1'b0},
    '{2'b11, 2'b00, 5'd16, 32'h02AAAAAB, 16'd65535, 31'h7FFFFFFF,   1'b0},
    '{2'b01, 2'b01, 5'd25, 32'hFFFFFFFF, 16'd65535, 31'd1,          1'b0},
    '{2'b00, 2'b10, 5'd4,  32'h03000000, 16'd9,     31'd11,         1'b1},
    '{2'b01, 2'b00, 5'd0,  32'h01000000, 16'd2,     31'd5,          1'b0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint lanes_of(input logic [1:0] p);
    return (p == 2'b00) ? 1 : (p == 2'b01) ? 2 : 4;
  endfunction

  function automatic longint k_of(input logic [1:0] f);
    return (f == 2'b00) ? 1 : (f == 2'b01) ? 66 : 68;
  endfunction

  function automatic longint exp_ofs(input vec_t v, input int lane);
    longint groups = longint'(lane) / lanes_of(v.pl);
    return (groups * k_of(v.fec) * longint'(v.ui)) / 4096;
  endfunction

  function automatic logic [31:0] exp_lat(input vec_t v);
    longint ns = (longint'(v.pma) * longint'(v.ui)) / 4096;
    longint s = (ns + longint'(v.ext)) % (64'sd1 << 31);
    return {1'b0, s[30:0]};
  endfunction

  // poke_at >= 0: drive a second start with changed inputs at that lane
  task automatic run_vec(input vec_t v, input int poke_at);
    int n;
    n = v.dis ? 0 : ((v.cnt > 20) ? 20 : int'(v.cnt));
    @(negedge clk);
    pl_sel = v.pl; fec_sel = v.fec; vl_count = v.cnt; ui_val = v.ui;
    pma_delay_ui = v.pma; ext_phy_delay = v.ext; disable_vl = v.dis;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7 lat_valid", 64'(lat_valid), 64'd1);
    check("R7 lat_word", 64'(lat_word), 64'(exp_lat(v)));
    if (n == 0) begin
      check("R8 no offsets", 64'(ofs_valid), 64'd0);
      check("R8 done with latency", 64'(done), 64'd1);
    end
    for (int i = 0; i < n; i++) begin
      if (i == poke_at) begin
        start = 1'b1; pl_sel = 2'b00; fec_sel = 2'b00; ui_val = 32'h7FFFFFFF;
        pma_delay_ui = 16'd1; ext_phy_delay = 31'd3; vl_count = 5'd2;
      end
      if (i == 0) check("R1 lane0 offset", 64'(ofs_value), 64'd0);
      check("R5 valid", 64'(ofs_valid), 64'd1);
      check("R5 index", 64'(ofs_index), 64'(i));
      check("R2 R3 R4 offset", 64'(ofs_value), 64'(exp_ofs(v, i)));
      check("R6 no done mid-stream", 64'(done), 64'd0);
      @(negedge clk);
      start = 1'b0;
      if (i > 0 && i == poke_at) begin
        check("R10 no restart", 64'(lat_valid), 64'd0);
        check("R10 lat_word held", 64'(lat_word), 64'(exp_lat(v)));
      end
    end
    if (n > 0) begin
      check("R6 done pulse", 64'(done), 64'd1);
      check("R6 valid low at done", 64'(ofs_valid), 64'd0);
    end
    @(negedge clk);
    check("R6 done one cycle", 64'(done), 64'd0);
    check("R7 lat_valid one cycle", 64'(lat_valid), 64'd0);
    check("R7 lat_word holds", 64'(lat_word), 64'(exp_lat(v)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset valid", 64'(ofs_valid), 64'd0);
    check("R11 reset done", 64'(done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after reset valid", 64'(ofs_valid), 64'd0);
    check("R11 after reset lat_valid", 64'(lat_valid), 64'd0);
    check("R11 after reset lat_word", 64'(lat_word), 64'd0);
    check("R11 after reset value", 64'(ofs_value), 64'd0);
    check("R11 after reset index", 64'(ofs_index), 64'd0);

    foreach (VECS[k]) run_vec(VECS[k], -1);

    // R9: count 25 clamps to 20 lanes (vector 4 covers, repeat with count 31)
    begin
      vec_t v = VECS[2];
      v.cnt = 5'd31;
      run_vec(v, -1);
    end

    // R10: second start mid-stream with different configuration is ignored
    run_vec(VECS[0], 3);
    run_vec(VECS[2], 7);

    // R8: disabled run directly after an active run
    run_vec(VECS[5], -1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule